// File: doc/BRIEF.md
# Synchronous Serial Port with Idle-Level Control

This block moves one byte at a time over a clocked synchronous serial link. The host loads a transmit byte, then sets a start bit in a small status register. The port shifts the byte out least significant bit first on the serial data output. It changes the output on each falling serial-clock edge and samples the serial data input on each rising edge. After eight rising edges the received byte can be read back. The serial clock comes from one of two places. It can be made inside the block by dividing the system clock, in which case it idles high. It can also be taken from an external pin, which is synchronised to the system clock before use.

When a transfer ends, the data output keeps the level of the last bit shifted out. The host can change that idle level by writing the level-control bit while the port is idle, and the bit always reads back the live level of the pin. In external-clock mode the partner may send clock pulses after a transfer has finished. The port latches such a pulse as an overrun error. The host can clear the error only by first reading the flag as 1 and then writing 0 to it.

Top module: `sio_port`

## Requirements
- R1: After reset the status register reads 0x80, the data output is low and the internal serial clock output is high.
- R2: Status bit 7 always reads 1 and bits 4 to 1 always read 0, whatever is written to them.
- R3: Once a transfer completes, the data output holds the last transmitted bit (bit 7 of the byte) until the host writes the status register.
- R4: A status write while idle drives the data output to the value of written bit 6 from the next cycle on. That level stays until the first falling serial-clock edge of the next transfer.
- R5: Status bit 6 reads the live level of the data output, not the value last written.
- R6: In external-clock mode, a falling edge on the external clock while idle, after a completed transfer, sets the overrun flag (status bit 5). In internal-clock mode the flag is never set.
- R7: The overrun flag clears only when 0 is written to bit 5 after the flag has been read as 1. Writing 1, or writing 0 without a prior read, leaves it set. A new overrun in the same cycle as a clear keeps it set.
- R8: While a transfer is in progress, status writes do not change the data output or the busy bit, and transmit-data writes do not change the shift register.
- R9: Writing 1 to status bit 0 while idle starts a transfer. Bit 0 reads 1 until the eighth rising serial-clock edge. Bits go out least significant first, and the eight sampled input bits form the received byte with the first bit in bit 0.
- R10: In internal-clock mode the serial clock output is enabled, idles high and has a period of 2*HALF_DIV system clocks. In external-clock mode the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_sel | input | 1 | 1: serial clock taken from sck_in; 0: generated internally |
| reg_wr | input | 1 | Status register write strobe |
| reg_rd | input | 1 | Status register read strobe (arms overrun clearing) |
| reg_wdata | input | 8 | Status register write data |
| reg_rdata | output | 8 | Status register read data |
| data_wr | input | 1 | Transmit byte write strobe |
| data_wdata | input | WIDTH | Transmit byte |
| data_rdata | output | WIDTH | Shift register contents (received byte after a transfer) |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Output enable for sck_out |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |

## Verification
A wrong bit counter shows up at once as a busy bit that clears too early or too late, and as a received byte whose bits have moved position. A fault in the edge sequencing sends bits out in the wrong order, or turns the idle level away from bit 7 of the byte, and this can be seen at the data pin on the same serial-clock edge. A wrong overrun or read-arming state shows in bit 5 within three system clocks of the stray external pulse, or on the very next cycle after the clearing write. A write that slips through during a transfer corrupts the pin level or the received byte, and this can be seen when the transfer completes.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int STAT_W   = 8;
  localparam int BIT_STF  = 0;
  localparam int BIT_ORER = 5;
  localparam int BIT_SOL  = 6;
  localparam int BIT_RSVD = 7;

  // Assemble the status read value from live state.
  function automatic logic [STAT_W-1:0] pack_status(input logic so_lvl,
                                                    input logic ovr,
                                                    input logic busy);
    logic [STAT_W-1:0] r;
    r           = '0;
    r[BIT_RSVD] = 1'b1;
    r[BIT_SOL]  = so_lvl;
    r[BIT_ORER] = ovr;
    r[BIT_STF]  = busy;
    return r;
  endfunction

  // Overrun flag update: a fresh event wins over a clear.
  function automatic logic ovr_next(input logic cur,
                                    input logic set_evt,
                                    input logic clr_evt);
    return set_evt | (cur & ~clr_evt);
  endfunction

  // Read arming: kept only while the flag stays set.
  function automatic logic arm_next(input logic armed,
                                    input logic rd_seen,
                                    input logic flag_after,
                                    input logic clr_evt);
    return flag_after & ~clr_evt & (armed | rd_seen);
  endfunction

endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall_evt,
  output logic rise_evt
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == CW'(HALF_DIV - 1));
  assign fall_evt = tick & sck;
  assign rise_evt = tick & ~sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b1;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sio_ext_edge.sv
module sio_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic si_in,
  output logic fall_evt,
  output logic rise_evt,
  output logic si_sync
);

  logic [SYNC_STAGES:0] sck_pipe;
  logic [SYNC_STAGES:0] si_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_pipe <= '1;
      si_pipe  <= '0;
    end else begin
      sck_pipe <= {sck_pipe[SYNC_STAGES-1:0], sck_in};
      si_pipe  <= {si_pipe[SYNC_STAGES-1:0], si_in};
    end
  end

  // Edge seen between the last synchronised stage and the history stage.
  assign fall_evt = sck_pipe[SYNC_STAGES] & ~sck_pipe[SYNC_STAGES-1];
  assign rise_evt = ~sck_pipe[SYNC_STAGES] & sck_pipe[SYNC_STAGES-1];
  assign si_sync  = si_pipe[SYNC_STAGES-1];

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [WIDTH-1:0] load_data,
  input  logic             start,
  input  logic             sol_we,
  input  logic             sol_val,
  input  logic             fall_evt,
  input  logic             rise_evt,
  input  logic             si_bit,
  output logic             so,
  output logic             busy,
  output logic             completed,
  output logic [WIDTH-1:0] rx_data
);

  localparam int BCW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] sr;
  logic [BCW-1:0]   rise_cnt;
  logic             last_rise;

  assign last_rise = rise_evt && (rise_cnt == BCW'(WIDTH - 1));
  assign rx_data   = sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      so        <= 1'b0;
      busy      <= 1'b0;
      completed <= 1'b0;
      rise_cnt  <= '0;
    end else if (busy) begin
      if (fall_evt) begin
        so <= sr[0];
        sr <= {1'b0, sr[WIDTH-1:1]};
      end else if (rise_evt) begin
        sr[WIDTH-1] <= si_bit;
        if (last_rise) begin
          busy      <= 1'b0;
          completed <= 1'b1;
          rise_cnt  <= '0;
        end else begin
          rise_cnt <= rise_cnt + 1'b1;
        end
      end
    end else begin
      if (sol_we) so <= sol_val;
      if (load_we) sr <= load_data;
      if (start) begin
        busy      <= 1'b1;
        completed <= 1'b0;
        rise_cnt  <= '0;
      end
    end
  end

endmodule

// File: rtl/sio_status.sv
module sio_status (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_ovr_bit,
  input  logic overrun_evt,
  output logic ovr_flag
);

  import sio_pkg::*;

  logic armed;
  logic clr_evt;
  logic ovr_n;

  assign clr_evt = wr_stb & ~wr_ovr_bit & armed & ovr_flag;
  assign ovr_n   = ovr_next(ovr_flag, overrun_evt, clr_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      armed    <= 1'b0;
    end else begin
      ovr_flag <= ovr_n;
      armed    <= arm_next(armed, rd_stb & ovr_flag, ovr_n, clr_evt);
    end
  end

endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             data_wr,
  input  logic [WIDTH-1:0] data_wdata,
  output logic [WIDTH-1:0] data_rdata,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             si,
  output logic             so
);

  logic busy, completed, ovr_flag;
  logic ctrl_wr, start_req, sol_we, load_we;
  logic int_sck, int_fall, int_rise;
  logic ext_fall, ext_rise, si_sync;
  logic fall_evt, rise_evt, si_bit, overrun_evt;
  logic unused_wbits;

  assign ctrl_wr   = reg_wr & ~busy;
  assign start_req = ctrl_wr & reg_wdata[BIT_STF];
  assign sol_we    = ctrl_wr;
  assign load_we   = data_wr & ~busy;

  sio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy & ~ext_clk_sel),
    .sck      (int_sck),
    .fall_evt (int_fall),
    .rise_evt (int_rise)
  );

  sio_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_in   (sck_in),
    .si_in    (si),
    .fall_evt (ext_fall),
    .rise_evt (ext_rise),
    .si_sync  (si_sync)
  );

  assign fall_evt    = busy & (ext_clk_sel ? ext_fall : int_fall);
  assign rise_evt    = busy & (ext_clk_sel ? ext_rise : int_rise);
  assign si_bit      = ext_clk_sel ? si_sync : si;
  assign overrun_evt = ext_clk_sel & ext_fall & ~busy & completed;

  sio_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_we   (load_we),
    .load_data (data_wdata),
    .start     (start_req),
    .sol_we    (sol_we),
    .sol_val   (reg_wdata[BIT_SOL]),
    .fall_evt  (fall_evt),
    .rise_evt  (rise_evt),
    .si_bit    (si_bit),
    .so        (so),
    .busy      (busy),
    .completed (completed),
    .rx_data   (data_rdata)
  );

  sio_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_stb      (reg_rd),
    .wr_stb      (reg_wr),
    .wr_ovr_bit  (reg_wdata[BIT_ORER]),
    .overrun_evt (overrun_evt),
    .ovr_flag    (ovr_flag)
  );

  assign reg_rdata    = pack_status(so, ovr_flag, busy);
  assign sck_oe       = ~ext_clk_sel;
  assign sck_out      = ext_clk_sel ? 1'b1 : int_sck;
  assign unused_wbits = ^{reg_wdata[7], reg_wdata[4:1]};

endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_clk_sel,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       sck_out,
  input logic       sck_oe,
  input logic       so,
  input logic       busy,
  input logic       fall_evt,
  input logic       rise_evt
);

  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] == 1'b1) && (reg_rdata[4:1] == 4'b0000));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !reg_wr) |=> $stable(so));

  assert_sol_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !busy) |=> (so == $past(reg_wdata[6])));

  assert_ovr_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[5]) |-> $past(ext_clk_sel));

  assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[5]) |-> $past(reg_wr && !reg_wdata[5]));

  assert_busy_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && !fall_evt) |=> $stable(so));

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rise_evt));

  assert_idle_sck_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ext_clk_sel) |-> (sck_out && sck_oe));

endmodule

bind sio_port sio_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_clk_sel (ext_clk_sel),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .sck_out     (sck_out),
  .sck_oe      (sck_oe),
  .so          (so),
  .busy        (busy),
  .fall_evt    (fall_evt),
  .rise_evt    (rise_evt)
);

// File: tb/test_sio_port.sv
module test_sio_port;

  localparam int W    = 8;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, ext_clk_sel = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, data_wr = 1'b0, sck_in = 1'b1, si = 1'b0;
  logic [7:0]   reg_wdata = '0, reg_rdata;
  logic [W-1:0] data_wdata = '0, data_rdata;
  logic sck_out, sck_oe, so;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sio_port #(.WIDTH(W), .HALF_DIV(HALF), .SYNC_STAGES(2)) i_sio_port (
    .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so)
  );

  // {external clock, tx byte, rx byte, idle level written before start}
  localparam logic [17:0] VEC [4] = '{
    {1'b0, 8'hA5, 8'h3C, 1'b0},
    {1'b1, 8'h5A, 8'hC3, 1'b1},
    {1'b0, 8'h80, 8'h01, 1'b1},
    {1'b1, 8'h01, 8'hFE, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_stat(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr_data(input logic [W-1:0] v);
    @(negedge clk); data_wr = 1'b1; data_wdata = v;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (reg_rdata[0] === 1'b1 && n < 2000) begin
      @(negedge clk); n++;
    end
    chk(req, {31'd0, reg_rdata[0]}, 32'd0);
  endtask

  task automatic int_xfer(input logic [7:0] rx, output logic [7:0] cap, output int per);
    int t0 = 0;
    per = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge sck_out);
      if (i == 0) t0 = cyc;
      if (i == 1) per = cyc - t0;
      si = rx[i];
      @(posedge sck_out);
      cap[i] = so;
    end
  endtask

  task automatic ext_xfer(input logic [7:0] rx, output logic [7:0] cap);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sck_in = 1'b0; si = rx[i];
      repeat (6) @(negedge clk);
      cap[i] = so;
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic ext_pulse();
    @(negedge clk); sck_in = 1'b0;
    repeat (6) @(negedge clk);
    sck_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (1_000_000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] cap;
    int per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", {24'd0, reg_rdata}, 32'h80);
    chk("R1 so", {31'd0, so}, 32'd0);
    chk("R1 sck", {31'd0, sck_out}, 32'd1);

    for (int v = 0; v < 4; v++) begin
      logic ext;
      logic [7:0] tx, rx;
      logic sol;
      {ext, tx, rx, sol} = VEC[v];
      @(negedge clk); ext_clk_sel = ext;
      wr_data(tx);
      wr_stat({1'b0, sol, 6'b0});
      chk("R4 sol level", {31'd0, so}, {31'd0, sol});
      chk("R5 readback", {31'd0, reg_rdata[6]}, {31'd0, sol});
      wr_stat({1'b0, sol, 5'b0, 1'b1});
      chk("R9 busy set", {31'd0, reg_rdata[0]}, 32'd1);
      if (ext) ext_xfer(rx, cap);
      else begin
        int_xfer(rx, cap, per);
        chk("R10 period", per, 2 * HALF);
      end
      wait_idle("R9 busy clear");
      chk("R9 tx order", {24'd0, cap}, {24'd0, tx});
      chk("R9 rx byte", {24'd0, data_rdata}, {24'd0, rx});
      chk("R3 last bit hold", {31'd0, so}, {31'd0, tx[7]});
      chk("R5 live level", {31'd0, reg_rdata[6]}, {31'd0, tx[7]});
      chk("R10 sck idle", {31'd0, sck_out}, 32'd1);
      chk("R10 sck_oe", {31'd0, sck_oe}, {31'd0, ~ext});
      wr_stat({1'b0, ~tx[7], 6'b0});
      chk("R3 level change", {31'd0, so}, {31'd0, ~tx[7]});
    end

    // R6 / R7 overrun in external mode (last vector completed externally)
    ext_pulse();
    chk("R6 overrun set", {31'd0, reg_rdata[5]}, 32'd1);
    wr_stat(8'h00);
    chk("R7 no clear without read", {31'd0, reg_rdata[5]}, 32'd1);
    pulse_rd();
    wr_stat(8'h20);
    chk("R7 write one ignored", {31'd0, reg_rdata[5]}, 32'd1);
    wr_stat(8'h00);
    chk("R7 cleared", {31'd0, reg_rdata[5]}, 32'd0);
    chk("R2 status after clear", {24'd0, reg_rdata}, 32'h80);

    // R6 no overrun in internal mode
    @(negedge clk); ext_clk_sel = 1'b0;
    wr_data(8'h33);
    wr_stat(8'h01);
    int_xfer(8'h0F, cap, per);
    wait_idle("R9 busy clear int");
    ext_pulse();
    chk("R6 internal no overrun", {31'd0, reg_rdata[5]}, 32'd0);

    // R8 writes during a transfer
    si = 1'b0;
    wr_data(8'hA5);
    wr_stat(8'h01);
    repeat (10) @(negedge clk);
    wr_stat(8'h00);
    chk("R8 busy kept", {31'd0, reg_rdata[0]}, 32'd1);
    wr_data(8'hFF);
    wait_idle("R8 busy clear");
    chk("R8 sol ignored", {31'd0, so}, 32'd1);
    chk("R8 data write ignored", {24'd0, data_rdata}, 32'h00);

    // R2 fixed bits
    wr_stat(8'h9E);
    chk("R2 fixed bits", {24'd0, reg_rdata}, 32'h80);
    wr_stat(8'h40);
    chk("R2 with sol", {24'd0, reg_rdata}, 32'hC0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule